// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a bus-mapped watchdog. A 32-bit down-counter is loaded by writing the count register. The write passes through a settling stage of `LOAD_LAT` cycles before the counting logic takes the new value. While the two-bit action field in the control register is non-zero, the counter drops by one each clock. When it hits zero, the block carries out the selected action. The choices are: nothing, a level interrupt, a level non-maskable interrupt, or a fixed-length chip reset request pulse. Software refreshes the timeout by writing the count register again.

A reset-cause flag records that the most recent reset came from a watchdog reset expiry. Only the power-on reset clears this flag; the chip reset that the block itself requests leaves it intact. Reads are combinational, so a read issued right after a write returns the written value. Software can therefore use a read to flush posted writes.

The control state machine has these states: `ST_OFF` (action field zero, counter frozen), `ST_RUN` (counting), `ST_IRQ`, `ST_NMI`, `ST_RST` (reset pulse in progress) and `ST_HOLD` (pulse done, counter parked at zero). Transitions are evaluated in this order:
- A zero action field forces `ST_OFF` from any state.
- Otherwise, a counter load forces `ST_RUN`.
- Otherwise, `ST_OFF` moves to `ST_RUN`.
- `ST_RUN` moves to the state chosen by the action when the counter is zero.
- `ST_RST` moves to `ST_HOLD` after `RST_CYC` cycles.
- `ST_IRQ`, `ST_NMI` and `ST_HOLD` stay where they are.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset the control register reads 0, the count register reads 0xFFFFFFFF, and `irq_o`, `nmi_o` and `chip_rst_req_o` are low.
- R2: The control register is at offset 0x00, with the action in bits [1:0] and the reset-cause flag in bit 31; the count register is at offset 0x04. Reads of any other offset return 0, and writes to them change no register and no output.
- R3: A read of the count register in the cycle after a write to it returns the written value.
- R4: A value written to the count register is loaded into the counter `LOAD_LAT` clock edges after the write edge. After that the count register reads the live counter, which falls by one per clock while the action field is non-zero.
- R5: With action 0 the counter holds its value and no output is asserted. Writing action 0 drops an asserted `irq_o` or `nmi_o` one cycle after the write.
- R6: With action 1 (interrupt), `irq_o` rises one cycle after the counter reaches zero and stays high.
- R7: With action 2 (non-maskable interrupt), `nmi_o` rises one cycle after the counter reaches zero and stays high, while `irq_o` stays low.
- R8: With action 3 (chip reset), `chip_rst_req_o` is high for exactly `RST_CYC` cycles starting one cycle after the counter reaches zero, and is not repeated.
- R9: After expiry the counter stays at zero until reloaded, and at most one of the three action outputs is high at any time.
- R10: The reset-cause flag sets when a reset-action expiry fires. It survives `rst_n`, is cleared by `por_n` or by writing 1 to control bit 31, and is unchanged by writing 0 there.
- R11: Reloading the counter while `irq_o` is high drops it once the load takes effect, and counting restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the cause flag |
| rst_n | input | 1 | Chip reset, active low; clears all but the cause flag |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt on expiry with action 1 |
| nmi_o | output | 1 | Level non-maskable interrupt on expiry with action 2 |
| chip_rst_req_o | output | 1 | Reset request pulse on expiry with action 3 |

## Verification
The embedded assertions check several properties on every cycle:
- the three action outputs are never high together;
- the counter moves only by a single decrement while armed, and freezes while disarmed or after reaching zero;
- the reset pulse never outlasts `RST_CYC`;
- the cause flag is set whenever a reset request rises;
- a count write is visible at the next read.

Other behaviour needs the directed scenarios to show it:
- the exact cycle on which a load lands after the settling latency;
- the exact cycle on which each action fires;
- the flag's survival across chip reset and its clearing by power-on reset;
- the handling of unmapped offsets.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_NMI  = 2'd2,
        ACT_RST  = 2'd3
    } wdt_act_e;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_RUN  = 3'd1,
        ST_IRQ  = 3'd2,
        ST_NMI  = 3'd3,
        ST_RST  = 3'd4,
        ST_HOLD = 3'd5
    } wdt_state_e;

    localparam logic [7:0] OFFS_CTRL  = 8'h00;
    localparam logic [7:0] OFFS_COUNT = 8'h04;
    localparam int         CAUSE_BIT  = 31;

endpackage

// File: rtl/wdt_load_sync.sv
module wdt_load_sync #(
    parameter int LAT = 4,
    parameter int W   = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] pend_o,
    output logic         busy_o,
    output logic         load_o
);

    logic [LAT-1:0] stage_q;
    logic [W-1:0]   pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr_i) begin
            pend_q <= data_i;
        end
    end

    generate
        if (LAT == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= wr_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[LAT-2:0], wr_i};
            end
        end
    endgenerate

    assign pend_o = pend_q;
    assign busy_o = |stage_q;
    assign load_o = stage_q[LAT-1];

    // R3: captured value is presented on the cycle after the write
    a_r3_pend_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (pend_o == $past(data_i)));

    // R4: a load only happens while a write is in flight
    a_r4_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> busy_o);

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int RST_CYC = 4,
    parameter int W       = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   act_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         irq_o,
    output logic         nmi_o,
    output logic         rst_req_o,
    output logic         rst_fire_o
);

    localparam int PW = $clog2(RST_CYC + 1);

    wdt_state_e     state_q, state_d;
    logic [W-1:0]   cnt_q;
    logic [PW-1:0]  pcnt_q;
    logic           armed;

    assign armed = (act_i != ACT_NONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!armed) begin
            state_d = ST_OFF;
        end else if (load_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_RUN;
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        unique case (wdt_act_e'(act_i))
                            ACT_IRQ:  state_d = ST_IRQ;
                            ACT_NMI:  state_d = ST_NMI;
                            ACT_RST:  state_d = ST_RST;
                            ACT_NONE: state_d = ST_OFF;
                        endcase
                    end
                end
                ST_IRQ:  state_d = ST_IRQ;
                ST_NMI:  state_d = ST_NMI;
                ST_RST: begin
                    if (pcnt_q == PW'(RST_CYC - 1)) state_d = ST_HOLD;
                end
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // counter and pulse timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            pcnt_q <= '0;
        end else begin
            if (load_i) begin
                cnt_q <= load_val_i;
            end else if (state_q == ST_RUN && armed && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state_q == ST_RST && state_d == ST_RST) pcnt_q <= pcnt_q + 1'b1;
            else                                        pcnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        irq_o     = 1'b0;
        nmi_o     = 1'b0;
        rst_req_o = 1'b0;
        unique case (state_q)
            ST_IRQ:  irq_o     = 1'b1;
            ST_NMI:  nmi_o     = 1'b1;
            ST_RST:  rst_req_o = 1'b1;
            default: ;
        endcase
        rst_fire_o = (state_d == ST_RST) && (state_q != ST_RST);
    end

    assign cnt_o = cnt_q;

    // R9: action outputs are mutually exclusive
    a_r9_onehot_out: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, nmi_o, rst_req_o}));

    // R4: armed counting steps down by exactly one
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && armed && !load_i && cnt_q != '0)
            |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: disarmed counter is frozen
    a_r5_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !load_i) |=> $stable(cnt_q));

    // R9: counter parked at zero without a load
    a_r9_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

    // R8: pulse never outlasts its length
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (pcnt_q < PW'(RST_CYC)));

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int LOAD_LAT = 4,
    parameter int RST_CYC  = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              chip_rst_req_o
);

    logic        sys_rst_n;
    logic        sel_ctrl, sel_cnt;
    logic [1:0]  act_q;
    logic        cause_q;
    logic [31:0] pend;
    logic        busy, load;
    logic [31:0] cnt;
    logic        rst_fire;

    assign sys_rst_n = por_n & rst_n;
    assign sel_ctrl  = (bus_addr == ADDR_W'(OFFS_CTRL));
    assign sel_cnt   = (bus_addr == ADDR_W'(OFFS_COUNT));

    // action field, cleared by any reset
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)              act_q <= ACT_NONE;
        else if (bus_we && sel_ctrl) act_q <= bus_wdata[1:0];
    end

    // reset-cause flag, power-on domain only; setting beats clearing
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if (rst_fire) begin
            cause_q <= 1'b1;
        end else if (bus_we && sel_ctrl && bus_wdata[CAUSE_BIT]) begin
            cause_q <= 1'b0;
        end
    end

    wdt_load_sync #(.LAT(LOAD_LAT), .W(DATA_W)) u_sync (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .wr_i   (bus_we && sel_cnt),
        .data_i (bus_wdata),
        .pend_o (pend),
        .busy_o (busy),
        .load_o (load)
    );

    wdt_fsm #(.RST_CYC(RST_CYC), .W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .act_i      (act_q),
        .load_i     (load),
        .load_val_i (pend),
        .cnt_o      (cnt),
        .irq_o      (irq_o),
        .nmi_o      (nmi_o),
        .rst_req_o  (chip_rst_req_o),
        .rst_fire_o (rst_fire)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[CAUSE_BIT] = cause_q;
            bus_rdata[1:0]       = act_q;
        end else if (sel_cnt) begin
            bus_rdata = busy ? pend : cnt;
        end
    end

    // R10: a rising reset request always finds the flag set
    a_r10_cause_set: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(chip_rst_req_o) |-> cause_q);

    // R3: count write readable on the following cycle
    a_r3_readback: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_we && sel_cnt) |=> (!sel_cnt || bus_rdata == $past(bus_wdata)));

    // R2: unmapped offsets read zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!sel_ctrl && !sel_cnt) |-> (bus_rdata == '0));

endmodule

// File: tb/wdt_top_bench.sv
module wdt_top_bench;

    localparam int LAT  = 4;
    localparam int RCYC = 4;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, nmi_o, chip_rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdt_top #(.ADDR_W(8), .LOAD_LAT(LAT), .RST_CYC(RCYC)) u_wdt_top (
        .clk            (clk),
        .por_n          (por_n),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .irq_o          (irq_o),
        .nmi_o          (nmi_o),
        .chip_rst_req_o (chip_rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic skip(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // load count while disarmed, let it settle, then arm; returns right after arming edge
    task automatic arm(input logic [1:0] act, input logic [31:0] val);
        wr(8'h00, 32'h0);
        wr(8'h04, val);
        skip(LAT + 1);
        wr(8'h00, {30'h0, act});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h04, v); chk("R1 count", v, 32'hFFFF_FFFF);
        chk("R1 outputs", {29'h0, irq_o, nmi_o, chip_rst_req_o}, 32'h0);
    endtask

    task automatic t_readback_hold;
        logic [31:0] v;
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, v); chk("R3 readback", v, 32'h1234_5678);
        skip(20);
        rd(8'h04, v); chk("R5 held while disarmed", v, 32'h1234_5678);
        chk("R5 no output", {29'h0, irq_o, nmi_o, chip_rst_req_o}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0000_0003);
        rd(8'h08, v); chk("R2 unmapped read", v, 32'h0);
        rd(8'h00, v); chk("R2 ctrl untouched", v, 32'h0);
        rd(8'h04, v); chk("R2 count untouched", v, 32'h1234_5678);
        skip(3);
        chk("R2 no output", {29'h0, irq_o, nmi_o, chip_rst_req_o}, 32'h0);
    endtask

    task automatic t_countdown;
        logic [31:0] v;
        wr(8'h00, 32'h1);
        wr(8'h04, 32'd100);
        skip(LAT);
        rd(8'h04, v); chk("R4 load after latency", v, 32'd100);
        skip(10);
        rd(8'h04, v); chk("R4 decrement", v, 32'd90);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        arm(2'd1, 32'd10);
        skip(11);
        chk("R6 irq before zero", {31'h0, irq_o}, 32'h0);
        skip(1);
        chk("R6 irq at expiry", {31'h0, irq_o}, 32'h1);
        skip(20);
        chk("R6 irq stays", {31'h0, irq_o}, 32'h1);
        rd(8'h04, v); chk("R9 parked at zero", v, 32'h0);
        chk("R9 exclusive", {30'h0, nmi_o, chip_rst_req_o}, 32'h0);
        wr(8'h04, 32'd50);
        skip(LAT);
        chk("R11 reload drops irq", {31'h0, irq_o}, 32'h0);
        skip(5);
        rd(8'h04, v); chk("R11 counting restarted", v, 32'd45);
    endtask

    task automatic t_irq_cancel;
        arm(2'd1, 32'd3);
        skip(5);
        chk("R6 irq up", {31'h0, irq_o}, 32'h1);
        wr(8'h00, 32'h0);
        skip(1);
        chk("R5 action 0 drops irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_nmi;
        arm(2'd2, 32'd6);
        skip(7);
        chk("R7 nmi before zero", {31'h0, nmi_o}, 32'h0);
        skip(1);
        chk("R7 nmi at expiry", {30'h0, nmi_o, irq_o}, 32'h2);
        skip(10);
        chk("R7 nmi stays", {31'h0, nmi_o}, 32'h1);
        wr(8'h00, 32'h0);
        skip(1);
        chk("R5 action 0 drops nmi", {31'h0, nmi_o}, 32'h0);
    endtask

    task automatic expire_reset(output int highs);
        highs = 0;
        arm(2'd3, 32'd5);
        skip(6);
        chk("R8 no pulse before zero", {31'h0, chip_rst_req_o}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            skip(1);
            if (chip_rst_req_o) highs++;
            if (irq_o || nmi_o) chk("R9 exclusive during pulse", 32'h1, 32'h0);
        end
    endtask

    task automatic t_reset_action;
        logic [31:0] v;
        int h;
        expire_reset(h);
        chk("R8 pulse length", h, RCYC);
        rd(8'h04, v); chk("R9 zero after pulse", v, 32'h0);
        rd(8'h00, v); chk("R10 flag set", v, 32'h8000_0003);
    endtask

    task automatic t_cause;
        logic [31:0] v;
        int h;
        @(negedge clk); rst_n = 1'b0;
        skip(2); rst_n = 1'b1; skip(1);
        rd(8'h00, v); chk("R10 flag survives chip reset", v, 32'h8000_0000);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R10 write 0 keeps flag", v, 32'h8000_0000);
        wr(8'h00, 32'h8000_0000);
        rd(8'h00, v); chk("R10 write 1 clears flag", v, 32'h0);
        expire_reset(h);
        rd(8'h00, v); chk("R10 flag set again", v[31], 1'b1);
        @(negedge clk); por_n = 1'b0;
        skip(2); por_n = 1'b1; skip(1);
        rd(8'h00, v); chk("R10 power-on clears flag", v, 32'h0);
    endtask

    initial begin
        skip(3);
        por_n = 1'b1; rst_n = 1'b1;
        skip(1);
        t_reset();
        t_readback_hold();
        t_unmapped();
        t_countdown();
        t_irq();
        t_irq_cancel();
        t_nmi();
        t_reset_action();
        t_cause();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule